// File: doc/BRIEF.md
# External Interrupt and Transfer-Request Detector

This block watches a set of external pins, one per channel, and turns events on them into requests. Each pin is first brought into the local clock domain by a synchroniser. Per channel, a two-bit detection setting chooses a high level, a low level, a rising edge or a falling edge as the trigger. A trigger sets that channel's factor flip-flop, which stays set until it is explicitly cleared. The flip-flop does not follow the pin.

An enable bit gates each factor flip-flop onto an output. A per-channel routing bit chooses where the gated factor goes. With the bit at 0 it drives a request to the interrupt controller, and software clears the flip-flop through a register write. With the bit at 1 it drives a transfer request to a transfer engine. The engine's per-channel acknowledge, given at the start of a transfer, clears the flip-flop. It also blinds detection on that channel for a few clocks. A source that still asserts its pin after that window is therefore seen as asking for another transfer.

A small register port, always addressed by a two-bit address, reads and writes the enable, factor, routing and detection settings.

Top module: `ext_event_detector`

## Requirements
- R1: After reset every register reads 0, and `irqReq` and `xferReq` are 0.
- R2: In a level mode, where the detection code is 0 for high and 1 for low, an active synchronised level sets the channel's factor bit. The factor register is at address 1 and bit i belongs to channel i. The bit reads 1 after the third rising clock edge that follows the pin change and still reads 0 after the second. An inactive level never sets it.
- R3: Once set, a factor bit stays 1 after the pin returns to its inactive state, until it is cleared by software or by a transfer acknowledge.
- R4: In an edge mode, where the detection code is 2 for rising and 3 for falling, a transition held at least three clocks sets the factor bit with the same three-edge latency. A steady pin never sets it.
- R5: Writing the factor register clears each bit written as 0 and leaves each bit written as 1 unchanged. If a detection occurs in the same cycle as the clear, the detection wins, so a level that is still active keeps the bit set.
- R6: `irqReq[i]` is 1 exactly when factor bit i, enable bit i (address 0) and the inverse of routing bit i (address 2) are all 1.
- R7: `xferReq[i]` is 1 exactly when factor bit i, enable bit i and routing bit i are all 1. `irqReq` and `xferReq` are never 1 on the same channel.
- R8: A 1 on `xferAck[i]` at a clock edge clears factor bit i at that edge, even if a detection occurs in the same cycle.
- R9: After an acknowledge, detection on that channel is blocked for the next MASK_CYCLES (default 3) clock edges. A request that is still active sets the factor bit again at the edge after those.
- R10: The enable (address 0) and routing (address 2) registers read back the value last written in their low NUM_CH bits. The detection register (address 3) reads back all 2*NUM_CH bits, with channel i at bits 2i+1:2i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pinIn | input | NUM_CH | External event pins, asynchronous |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 enable, 1 factor, 2 routing, 3 detection |
| wrData | input | 2*NUM_CH | Register write data |
| rdData | output | 2*NUM_CH | Register read data for `addr`, combinational |
| xferAck | input | NUM_CH | Per-channel transfer-start acknowledge |
| irqReq | output | NUM_CH | Per-channel request to the interrupt controller |
| xferReq | output | NUM_CH | Per-channel request to the transfer engine |

## Verification
The bound checker checks on every cycle that the two request outputs never overlap and never assert without a factor bit. It also checks that an acknowledge always clears its factor bit, that a masked channel cannot set its bit, and that a set bit survives any cycle without an acknowledge or a zero write. The exact three-edge detection latency, the mode-dependent choice of trigger, the detection-beats-clear priority and the exact edge at which a lingering transfer request returns can only be shown by the bench's timed scenarios. The bench sweeps every channel through all four detection codes and all enable and routing combinations.

// File: rtl/ext_evt_pkg.sv
package ext_evt_pkg;

  typedef enum logic [1:0] {
    REG_ENABLE = 2'd0,
    REG_FACTOR = 2'd1,
    REG_ROUTE  = 2'd2,
    REG_DETECT = 2'd3
  } regAddr_e;

  typedef enum logic [1:0] {
    DET_HIGH = 2'd0,
    DET_LOW  = 2'd1,
    DET_RISE = 2'd2,
    DET_FALL = 2'd3
  } detMode_e;

  // write strobes from control to datapath
  typedef struct packed {
    logic enableWr;
    logic factorWr;
    logic routeWr;
    logic detectWr;
  } regStrobe_t;

endpackage

// File: rtl/ext_evt_sync.sv
module ext_evt_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '0;
    end else begin
      stage[0] <= din;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/ext_evt_ctl.sv
module ext_evt_ctl
  import ext_evt_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int MASK_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [NUM_CH-1:0] xferAck,
  output regStrobe_t        strobe,
  output logic [NUM_CH-1:0] maskBusy
);

  localparam int CNT_W = (MASK_CYCLES < 1) ? 1 : $clog2(MASK_CYCLES + 1);

  always_comb begin
    strobe.enableWr = wrEn && (addr == REG_ENABLE);
    strobe.factorWr = wrEn && (addr == REG_FACTOR);
    strobe.routeWr  = wrEn && (addr == REG_ROUTE);
    strobe.detectWr = wrEn && (addr == REG_DETECT);
  end

  // per-channel blind window after a transfer start
  for (genvar i = 0; i < NUM_CH; i++) begin : g_mask
    logic [CNT_W-1:0] maskCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                maskCnt <= '0;
      else if (xferAck[i])      maskCnt <= CNT_W'(MASK_CYCLES);
      else if (maskCnt != '0)   maskCnt <= maskCnt - 1'b1;
    end

    assign maskBusy[i] = (maskCnt != '0);
  end

endmodule

// File: rtl/ext_evt_datapath.sv
module ext_evt_datapath
  import ext_evt_pkg::*;
#(
  parameter  int NUM_CH = 8,
  localparam int DATA_W = 2 * NUM_CH
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_CH-1:0] pinSync,
  input  logic [NUM_CH-1:0] maskBusy,
  input  logic [NUM_CH-1:0] xferAck,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] irqReq,
  output logic [NUM_CH-1:0] xferReq,
  output logic [NUM_CH-1:0] factorQ
);

  logic [NUM_CH-1:0] enableQ;
  logic [NUM_CH-1:0] routeQ;
  logic [DATA_W-1:0] detectQ;
  logic [NUM_CH-1:0] prevSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ  <= '0;
      routeQ   <= '0;
      detectQ  <= '0;
      prevSync <= '0;
    end else begin
      prevSync <= pinSync;
      if (strobe.enableWr) enableQ <= wrData[NUM_CH-1:0];
      if (strobe.routeWr)  routeQ  <= wrData[NUM_CH-1:0];
      if (strobe.detectWr) detectQ <= wrData;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic     hit;
    logic     facBit;
    detMode_e mode;

    assign mode = detMode_e'(detectQ[2*i +: 2]);

    always_comb begin
      unique case (mode)
        DET_HIGH: hit =  pinSync[i];
        DET_LOW:  hit = ~pinSync[i];
        DET_RISE: hit =  pinSync[i] & ~prevSync[i];
        DET_FALL: hit = ~pinSync[i] &  prevSync[i];
        default:  hit = 1'b0;
      endcase
    end

    // acknowledge beats detection, detection beats a software clear
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                 facBit <= 1'b0;
      else if (xferAck[i])                       facBit <= 1'b0;
      else if (hit && !maskBusy[i])              facBit <= 1'b1;
      else if (strobe.factorWr && !wrData[i])    facBit <= 1'b0;
    end

    assign factorQ[i] = facBit;
    assign irqReq[i]  = facBit & enableQ[i] & ~routeQ[i];
    assign xferReq[i] = facBit & enableQ[i] &  routeQ[i];
  end

  always_comb begin
    rdData = '0;
    unique case (regAddr_e'(addr))
      REG_ENABLE: rdData[NUM_CH-1:0] = enableQ;
      REG_FACTOR: rdData[NUM_CH-1:0] = factorQ;
      REG_ROUTE:  rdData[NUM_CH-1:0] = routeQ;
      REG_DETECT: rdData             = detectQ;
      default:    rdData             = '0;
    endcase
  end

endmodule

// File: rtl/ext_event_detector.sv
module ext_event_detector
  import ext_evt_pkg::*;
#(
  parameter  int NUM_CH      = 8,
  parameter  int SYNC_STAGES = 2,
  parameter  int MASK_CYCLES = 3,
  localparam int DATA_W      = 2 * NUM_CH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] pinIn,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [NUM_CH-1:0] xferAck,
  output logic [NUM_CH-1:0] irqReq,
  output logic [NUM_CH-1:0] xferReq
);

  regStrobe_t        strobe;
  logic [NUM_CH-1:0] maskBusy;
  logic [NUM_CH-1:0] pinSync;
  logic [NUM_CH-1:0] factorQ;

  ext_evt_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (pinIn),
    .dout (pinSync)
  );

  ext_evt_ctl #(.NUM_CH(NUM_CH), .MASK_CYCLES(MASK_CYCLES)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .addr     (addr),
    .xferAck  (xferAck),
    .strobe   (strobe),
    .maskBusy (maskBusy)
  );

  ext_evt_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .addr     (addr),
    .wrData   (wrData),
    .pinSync  (pinSync),
    .maskBusy (maskBusy),
    .xferAck  (xferAck),
    .rdData   (rdData),
    .irqReq   (irqReq),
    .xferReq  (xferReq),
    .factorQ  (factorQ)
  );

endmodule

// File: rtl/ext_event_detector_chk.sv
module ext_event_detector_chk #(
  parameter int NUM_CH = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [1:0]            addr,
  input logic [2*NUM_CH-1:0]   wrData,
  input logic [NUM_CH-1:0]     xferAck,
  input logic [NUM_CH-1:0]     irqReq,
  input logic [NUM_CH-1:0]     xferReq,
  input logic [NUM_CH-1:0]     factorQ,
  input logic [NUM_CH-1:0]     maskBusy
);

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq & xferReq) == '0);

  a_r6_req_needs_factor: assert property (@(posedge clk) disable iff (!rstN)
    ((irqReq | xferReq) & ~factorQ) == '0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_prop
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
      xferAck[i] |=> !factorQ[i]);

    a_r9_mask_blocks: assert property (@(posedge clk) disable iff (!rstN)
      (maskBusy[i] && !factorQ[i]) |=> !factorQ[i]);

    a_r3_factor_holds: assert property (@(posedge clk) disable iff (!rstN)
      (factorQ[i] && !xferAck[i] && !(wrEn && addr == 2'd1 && !wrData[i]))
        |=> factorQ[i]);
  end

endmodule

bind ext_event_detector ext_event_detector_chk #(.NUM_CH(NUM_CH)) chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .addr     (addr),
  .wrData   (wrData),
  .xferAck  (xferAck),
  .irqReq   (irqReq),
  .xferReq  (xferReq),
  .factorQ  (factorQ),
  .maskBusy (maskBusy)
);

// File: tb/ext_event_detector_test.sv
module ext_event_detector_test;

  localparam int NCH = 8;
  localparam int DW  = 2 * NCH;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NCH-1:0] pinIn = '0;
  logic           wrEn = 1'b0;
  logic [1:0]     addr = 2'd0;
  logic [DW-1:0]  wrData = '0;
  logic [DW-1:0]  rdData;
  logic [NCH-1:0] xferAck = '0;
  logic [NCH-1:0] irqReq;
  logic [NCH-1:0] xferReq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ext_event_detector #(.NUM_CH(NCH)) uut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .xferAck(xferAck),
    .irqReq(irqReq), .xferReq(xferReq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [DW-1:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [DW-1:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic ack(input logic [NCH-1:0] m);
    xferAck = m;
    @(negedge clk);
    xferAck = '0;
  endtask

  function automatic logic activeLvl(input int m);
    return (m == 0 || m == 2);
  endfunction

  logic [DW-1:0] rv;

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      regRead(2'(a), rv);
      check("R1 reg", 32'(rv), 0);
    end
    check("R1 irqReq", 32'(irqReq), 0);
    check("R1 xferReq", 32'(xferReq), 0);
    rstN = 1'b1;
    step(2);

    // R10 readback
    regWrite(2'd0, 16'h00A5); regRead(2'd0, rv); check("R10 enable", 32'(rv), 32'h00A5);
    regWrite(2'd2, 16'hFF5A); regRead(2'd2, rv); check("R10 route", 32'(rv), 32'h005A);
    regWrite(2'd3, 16'h1234); regRead(2'd3, rv); check("R10 detect", 32'(rv), 32'h1234);
    regWrite(2'd0, '0); regWrite(2'd2, '0); regWrite(2'd3, '0);
    step(4);
    regWrite(2'd1, '0);

    // sweep every channel through every detection code
    for (int ch = 0; ch < NCH; ch++) begin
      for (int m = 0; m < 4; m++) begin
        logic act;
        string tagSet;
        logic [DW-1:0] one;
        act = activeLvl(m);
        tagSet = (m < 2) ? "R2" : "R4";
        one = DW'(1) << ch;
        pinIn = '0;
        pinIn[ch] = ~act;
        regWrite(2'd3, DW'(m) << (2 * ch));
        step(4);
        regWrite(2'd1, '0);
        regRead(2'd1, rv); check("R5 clear", 32'(rv), 0);
        step(3);
        regRead(2'd1, rv); check({tagSet, " idle no set"}, 32'(rv), 0);

        pinIn[ch] = act;
        step(2);
        regRead(2'd1, rv); check({tagSet, " latency"}, 32'(rv), 0);
        step(1);
        regRead(2'd1, rv); check({tagSet, " set"}, 32'(rv), 32'(one));
        step(1);
        pinIn[ch] = ~act;
        step(4);
        regRead(2'd1, rv); check("R3 held", 32'(rv), 32'(one));

        for (int en = 0; en < 2; en++) begin
          for (int xm = 0; xm < 2; xm++) begin
            regWrite(2'd0, DW'(en) << ch);
            regWrite(2'd2, DW'(xm) << ch);
            check("R6 irq gate", 32'(irqReq), 32'((en & (1 - xm)) << ch));
            check("R7 xfer gate", 32'(xferReq), 32'((en & xm) << ch));
          end
        end
        regWrite(2'd0, '0);
        regWrite(2'd2, '0);

        regWrite(2'd1, {DW{1'b1}});
        regRead(2'd1, rv); check("R5 write one keeps", 32'(rv), 32'(one));
        regWrite(2'd1, ~one);
        regRead(2'd1, rv); check("R5 write zero clears", 32'(rv), 0);

        if (m < 2) begin
          pinIn[ch] = act;
          step(3);
          regRead(2'd1, rv); check("R2 reset again", 32'(rv), 32'(one));
          regWrite(2'd1, '0);
          regRead(2'd1, rv); check("R5 detect wins", 32'(rv), 32'(one));
          pinIn[ch] = ~act;
          step(3);
          regWrite(2'd1, '0);
          regRead(2'd1, rv); check("R5 clear after", 32'(rv), 0);
        end else begin
          step(4);
          regRead(2'd1, rv); check("R4 steady no set", 32'(rv), 0);
        end
      end
    end

    // transfer path on channel 3, high level
    pinIn = '0;
    regWrite(2'd3, '0);
    step(4);
    regWrite(2'd1, '0);
    regWrite(2'd0, 16'h0008);
    regWrite(2'd2, 16'h0008);
    pinIn[3] = 1'b1;
    step(3);
    check("R7 xfer request", 32'(xferReq), 32'h08);
    check("R7 no irq", 32'(irqReq), 0);
    ack(8'h08);
    check("R8 ack clears", 32'(xferReq), 0);
    for (int k = 1; k <= 3; k++) begin
      step(1);
      check("R9 masked", 32'(xferReq), 0);
    end
    step(1);
    check("R9 lingering request returns", 32'(xferReq), 32'h08);
    pinIn[3] = 1'b0;
    ack(8'h08);
    check("R8 ack clears again", 32'(xferReq), 0);
    step(8);
    check("R9 withdrawn no request", 32'(xferReq), 0);
    regRead(2'd1, rv); check("R9 factor idle", 32'(rv), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule